// File: doc/BRIEF.md
# Indexed Block Register Slave for Clock Distribution Control

This block is the control port of a clock distribution chip. It listens on a two-wire serial bus (I2C, slave only, 7-bit addressing) and holds a handful of byte-wide control registers. Two output-enable bits and two divider bytes leave the block as plain outputs, and a fixed identification byte can be read back. The bus lines arrive as inputs. The block drives the data line through a single pull-down enable output, so the pad stays open-drain.

A write transfer is made of the write address byte, then a starting register index, then a byte count, then up to that many data bytes. The data bytes land at consecutive registers, and every header byte and accepted data byte is acknowledged. A read transfer first sets the index with a short write header. The host then issues a repeated start with the read address. The slave returns the byte count from the most recent write header, followed by register contents from the index upward. The index advances each time the host acknowledges, and a not-acknowledge from the host ends the transfer.

Both bus lines pass through synchronizers into a system clock domain that is much faster than the bus clock. A start or stop condition is detected as a data-line edge while the clock line is high. There is no clock stretching, no 10-bit addressing and no general call.

Top module: `clkdist_cfg_slave`

## Requirements
- R1: After reset, `out3_en` and `out4_en` are 1, `pwr_div1` is 0x0F, `pwr_div2` is 0x2E, and `sda_pull_low` is 0.
- R2: The slave answers the 7-bit address 0x6A. The first byte after a start is address[6:0] followed by R/W (bit 0, 1 = read), so the write form is 0xD4 and the read form is 0xD5. A matching byte is acknowledged by holding SDA low through the 9th clock.
- R3: An address byte that does not match is not acknowledged. Every byte after it is ignored, with no acknowledge and no register change, until the next start condition.
- R4: A write carries index N, then count X, then data bytes. Each of these is acknowledged, and data byte k (k = 0..X-1) is stored at register N+k. The registers that drive outputs update without any further action.
- R5: When X data bytes have already been accepted, a further data byte in the same transfer is not acknowledged and changes no register.
- R6: In register 0, bit 5 drives `out3_en` and bit 4 drives `out4_en`, and both are writable. The other six bits of register 0 ignore writes and read as 0.
- R7: Register 1 is `pwr_div1` and register 2 is `pwr_div2`. Register 6 always reads 0x01 (revision 0 in bits 7:4, vendor 1 in bits 3:0). Registers 3 to 5, register 6 and every index of 7 or more ignore writes. Registers 3 to 5 and indices of 7 or more read 0, and data bytes written to them are still acknowledged.
- R8: After a repeated start with 0xD5, the first byte returned is the count X from the last write header, and then come the registers N, N+1, and so on, one per host acknowledge. A host not-acknowledge makes the slave release SDA and stay idle until the next start.
- R9: `sda_pull_low` changes only in the cycle after a detected SCL falling edge, start or stop, and it is 0 after every stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull_low | output | 1 | 1 drives the data line low; 0 releases it |
| out3_en | output | 1 | Enable for buffered output 3 (register 0 bit 5) |
| out4_en | output | 1 | Enable for buffered output 4 (register 0 bit 4) |
| pwr_div1 | output | 8 | Divider setting for power-control clock 1 (register 1) |
| pwr_div2 | output | 8 | Divider setting for power-control clock 2 (register 2) |

## Verification
On every cycle, the assertions check four things. The data-line driver moves only after an SCL fall, start or stop, and it lets go after a stop. A foreign address or a byte beyond the count never pulls the line low. The control registers hold still when no write strobe fires and when the strobe targets a read-only index. The scenarios alone show that bytes land at the right index, that the count byte comes first in a read, that reserved bits read back as zero, and that a not-acknowledge ends the read. These behaviours depend on whole byte sequences, so the bench shows them by comparing acknowledge bits and returned bytes against a scoreboard.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_OFS,
    PH_CNT,
    PH_WDATA,
    PH_RDATA
  } phase_e;

  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_DIVA = 1;
  localparam int unsigned IDX_ID   = 6;
  localparam int unsigned BIT_OE3  = 5;
  localparam int unsigned BIT_OE4  = 4;

  function automatic logic addr_match(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  function automatic logic [7:0] ctrl_image(input logic oe3, input logic oe4);
    logic [7:0] v;
    v = '0;
    v[BIT_OE3] = oe3;
    v[BIT_OE4] = oe4;
    return v;
  endfunction

endpackage

// File: rtl/line_sampler.sv
module line_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt,
  output logic sda_bit
);
  logic [STAGES:0] scl_sh, sda_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_in};
      sda_sh <= {sda_sh[STAGES-1:0], sda_in};
    end
  end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now = scl_sh[STAGES-1];
  assign scl_old = scl_sh[STAGES];
  assign sda_now = sda_sh[STAGES-1];
  assign sda_old = sda_sh[STAGES];

  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_evt = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_evt  = scl_now & scl_old & ~sda_old & sda_now;
  assign sda_bit   = sda_now;
endmodule

// File: rtl/serial_engine.sv
module serial_engine
  import cfgslv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       sda_bit,
  input  logic [7:0] rd_data,
  output logic [7:0] ptr_o,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       sda_low
);
  phase_e     phase, pend;
  logic [3:0] bitcnt;
  logic       in_ack, drv, mack;
  logic [7:0] shreg, txsh, ptr, cnt_reg, wr_left;

  logic rx_phase, byte_done, addr_hit, room_left;
  assign rx_phase  = (phase == PH_ADDR) || (phase == PH_OFS) ||
                     (phase == PH_CNT)  || (phase == PH_WDATA);
  assign byte_done = rx_phase && scl_fall && !in_ack && (bitcnt == 4'd8);
  assign addr_hit  = addr_match(shreg, DEV_ADDR);
  assign room_left = (wr_left != 8'd0);

  assign wr_en   = byte_done && (phase == PH_WDATA) && room_left;
  assign wr_data = shreg;
  assign ptr_o   = ptr;
  assign sda_low = drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      pend    <= PH_IDLE;
      bitcnt  <= '0;
      in_ack  <= 1'b0;
      drv     <= 1'b0;
      mack    <= 1'b0;
      shreg   <= '0;
      txsh    <= '0;
      ptr     <= '0;
      cnt_reg <= '0;
      wr_left <= '0;
    end else if (start_evt) begin
      phase  <= PH_ADDR;
      bitcnt <= '0;
      in_ack <= 1'b0;
      drv    <= 1'b0;
    end else if (stop_evt) begin
      phase  <= PH_IDLE;
      bitcnt <= '0;
      in_ack <= 1'b0;
      drv    <= 1'b0;
    end else if (phase == PH_RDATA) begin
      if (scl_rise) begin
        if (in_ack) mack <= ~sda_bit;
        else        bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall) begin
        if (in_ack) begin
          in_ack <= 1'b0;
          bitcnt <= '0;
          if (mack) begin
            txsh <= rd_data;
            drv  <= ~rd_data[7];
            ptr  <= ptr + 8'd1;
          end else begin
            phase <= PH_IDLE;
            drv   <= 1'b0;
          end
        end else if (bitcnt == 4'd8) begin
          drv    <= 1'b0;
          in_ack <= 1'b1;
        end else if (bitcnt != 4'd0) begin
          txsh <= {txsh[6:0], 1'b0};
          drv  <= ~txsh[6];
        end
      end
    end else if (rx_phase) begin
      if (scl_rise && !in_ack && bitcnt < 4'd8) begin
        shreg  <= {shreg[6:0], sda_bit};
        bitcnt <= bitcnt + 4'd1;
      end else if (byte_done) begin
        case (phase)
          PH_ADDR: begin
            if (addr_hit) begin
              drv <= 1'b1; in_ack <= 1'b1;
              pend <= shreg[0] ? PH_RDATA : PH_OFS;
            end else begin
              phase <= PH_IDLE;
            end
          end
          PH_OFS: begin
            ptr <= shreg; drv <= 1'b1; in_ack <= 1'b1; pend <= PH_CNT;
          end
          PH_CNT: begin
            cnt_reg <= shreg; wr_left <= shreg;
            drv <= 1'b1; in_ack <= 1'b1; pend <= PH_WDATA;
          end
          default: begin
            if (room_left) begin
              wr_left <= wr_left - 8'd1;
              ptr     <= ptr + 8'd1;
              drv <= 1'b1; in_ack <= 1'b1; pend <= PH_WDATA;
            end else begin
              phase <= PH_IDLE;
            end
          end
        endcase
      end else if (scl_fall && in_ack) begin
        in_ack <= 1'b0;
        bitcnt <= '0;
        phase  <= pend;
        if (pend == PH_RDATA) begin
          txsh <= cnt_reg;
          drv  <= ~cnt_reg[7];
        end else begin
          drv <= 1'b0;
        end
      end
    end
  end

  // R9: the data line only moves right after an SCL fall, start or stop
  assert_sda_on_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low) |-> $past(scl_fall || start_evt || stop_evt));

  // R9: a stop always leaves the data line released
  assert_release_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_low);

  // R3: a foreign address is never acknowledged
  assert_foreign_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_ADDR && !addr_hit) |=> (!sda_low && phase == PH_IDLE));

  // R5: a byte beyond the count is neither acknowledged nor written
  assert_count_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_WDATA && !room_left) |-> (!wr_en ##1 !sda_low));
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
  import cfgslv_pkg::*;
#(
  parameter logic [7:0] DIV1_RST = 8'h0F,
  parameter logic [7:0] DIV2_RST = 8'h2E,
  parameter logic [7:0] ID_VALUE = 8'h01,
  parameter int         NUM_DIV  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_idx,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_idx,
  output logic [7:0] rd_data,
  output logic       oe3,
  output logic       oe4,
  output logic [NUM_DIV-1:0][7:0] div_o
);
  localparam logic [1:0][7:0] DIV_RST = {DIV2_RST, DIV1_RST};

  logic                   oe3_q, oe4_q;
  logic [NUM_DIV-1:0][7:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe3_q <= 1'b1;
      oe4_q <= 1'b1;
    end else if (wr_en && wr_idx == 8'(IDX_CTRL)) begin
      oe3_q <= wr_data[BIT_OE3];
      oe4_q <= wr_data[BIT_OE4];
    end
  end

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    div_q[g] <= DIV_RST[g];
      else if (wr_en && wr_idx == 8'(IDX_DIVA + g)) div_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_idx == 8'(IDX_CTRL))    rd_data = ctrl_image(oe3_q, oe4_q);
    else if (rd_idx == 8'(IDX_ID)) rd_data = ID_VALUE;
    else begin
      for (int k = 0; k < NUM_DIV; k++)
        if (rd_idx == 8'(IDX_DIVA + k)) rd_data = div_q[k];
    end
  end

  assign oe3   = oe3_q;
  assign oe4   = oe4_q;
  assign div_o = div_q;

  // R4: control state changes only on a write strobe
  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(div_q) && $stable(oe3_q) && $stable(oe4_q)));

  // R7: writes to read-only or unmapped indices change nothing
  assert_ro_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx > 8'(IDX_DIVA + NUM_DIV - 1)) |=>
      ($stable(div_q) && $stable(oe3_q) && $stable(oe4_q)));
endmodule

// File: rtl/clkdist_cfg_slave.sv
module clkdist_cfg_slave
  import cfgslv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h6A,
  parameter logic [7:0] DIV1_RST    = 8'h0F,
  parameter logic [7:0] DIV2_RST    = 8'h2E,
  parameter logic [7:0] ID_VALUE    = 8'h01,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull_low,
  output logic       out3_en,
  output logic       out4_en,
  output logic [7:0] pwr_div1,
  output logic [7:0] pwr_div2
);
  logic scl_rise, scl_fall, start_evt, stop_evt, sda_bit;
  logic wr_en;
  logic [7:0] ptr, wr_data, rd_data;
  logic [1:0][7:0] div_w;

  line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_bit(sda_bit)
  );

  serial_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_bit(sda_bit),
    .rd_data(rd_data), .ptr_o(ptr), .wr_en(wr_en), .wr_data(wr_data),
    .sda_low(sda_pull_low)
  );

  ctl_regfile #(
    .DIV1_RST(DIV1_RST), .DIV2_RST(DIV2_RST), .ID_VALUE(ID_VALUE), .NUM_DIV(2)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(ptr), .wr_data(wr_data),
    .rd_idx(ptr), .rd_data(rd_data),
    .oe3(out3_en), .oe4(out4_en), .div_o(div_w)
  );

  assign pwr_div1 = div_w[0];
  assign pwr_div2 = div_w[1];
endmodule

// File: tb/test_clkdist_cfg_slave.sv
module test_clkdist_cfg_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic s_low, oe3, oe4;
  logic [7:0] d1, d2;
  wire sda_line = ~(m_low | s_low);

  clkdist_cfg_slave i_clkdist_cfg_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .sda_pull_low(s_low), .out3_en(oe3), .out4_en(oe4),
    .pwr_div1(d1), .pwr_div2(d2)
  );

  typedef struct { string tag; logic [7:0] val; } item_t;
  item_t exp_q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;
  event obs_ev;
  logic [7:0] obs_val;

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(obs_ev);
    if (exp_q.size() == 0) check("unexpected observation", obs_val, 8'hxx);
    else begin
      item_t it;
      it = exp_q.pop_front();
      check(it.tag, obs_val, it.val);
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic observe(input logic [7:0] v); obs_val = v; -> obs_ev; #1; endtask

  task automatic bus_start(); m_low = 1; wq(); wq(); scl = 0; wq(); endtask
  task automatic bus_rstart(); m_low = 0; wq(); scl = 1; wq(); m_low = 1; wq(); scl = 0; wq(); endtask
  task automatic bus_stop(); m_low = 1; wq(); scl = 1; wq(); m_low = 0; wq(); wq(); endtask
  task automatic put_bit(input logic b); m_low = !b; wq(); scl = 1; wq(); wq(); scl = 0; wq(); endtask

  // ack expected: 0 = acknowledged, 1 = not acknowledged
  task automatic send_byte(input logic [7:0] b, input logic nack_exp, input string tag);
    logic a;
    exp_q.push_back('{tag, {7'd0, nack_exp}});
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_low = 0; wq(); scl = 1; wq(); a = sda_line; wq(); scl = 0; wq();
    observe({7'd0, a});
  endtask

  task automatic recv_byte(input logic [7:0] exp, input logic last, input string tag);
    logic [7:0] v;
    v = '0;
    exp_q.push_back('{tag, exp});
    for (int i = 0; i < 8; i++) begin
      m_low = 0; wq(); scl = 1; wq(); v = {v[6:0], sda_line}; wq(); scl = 0; wq();
    end
    put_bit(last);
    observe(v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 out3_en", {7'd0, oe3}, 8'h01);
    check("R1 out4_en", {7'd0, oe4}, 8'h01);
    check("R1 pwr_div1", d1, 8'h0F);
    check("R1 pwr_div2", d2, 8'h2E);
    check("R1 sda released", {7'd0, s_low}, 8'h00);

    // R2 R4: write two dividers from index 1
    bus_start();
    send_byte(8'hD4, 0, "R2 write address ack");
    send_byte(8'h01, 0, "R4 index ack");
    send_byte(8'h02, 0, "R4 count ack");
    send_byte(8'h33, 0, "R4 data0 ack");
    send_byte(8'h44, 0, "R4 data1 ack");
    bus_stop();
    check("R4 pwr_div1", d1, 8'h33);
    check("R4 pwr_div2", d2, 8'h44);
    check("R9 sda after stop", {7'd0, s_low}, 8'h00);

    // R6: enables off, then all ones
    bus_start();
    send_byte(8'hD4, 0, "R2 ack"); send_byte(8'h00, 0, "R6 index"); send_byte(8'h01, 0, "R6 count");
    send_byte(8'h00, 0, "R6 data");
    bus_stop();
    check("R6 out3_en cleared", {7'd0, oe3}, 8'h00);
    check("R6 out4_en cleared", {7'd0, oe4}, 8'h00);
    bus_start();
    send_byte(8'hD4, 0, "R2 ack"); send_byte(8'h00, 0, "R6 index"); send_byte(8'h01, 0, "R6 count");
    send_byte(8'hFF, 0, "R6 data");
    bus_stop();
    check("R6 out3_en set", {7'd0, oe3}, 8'h01);
    check("R6 out4_en set", {7'd0, oe4}, 8'h01);

    // R5: byte beyond the count
    bus_start();
    send_byte(8'hD4, 0, "R2 ack"); send_byte(8'h01, 0, "R5 index"); send_byte(8'h01, 0, "R5 count");
    send_byte(8'h55, 0, "R5 data in range");
    send_byte(8'h66, 1, "R5 data beyond count nack");
    bus_stop();
    check("R5 pwr_div1", d1, 8'h55);
    check("R5 pwr_div2 untouched", d2, 8'h44);

    // R3: foreign address
    bus_start();
    send_byte(8'hA4, 1, "R3 foreign address nack");
    send_byte(8'h01, 1, "R3 ignored index");
    send_byte(8'h01, 1, "R3 ignored count");
    send_byte(8'h77, 1, "R3 ignored data");
    bus_stop();
    check("R3 pwr_div1 untouched", d1, 8'h55);

    // R7: writes to read-only and reserved registers
    bus_start();
    send_byte(8'hD4, 0, "R2 ack"); send_byte(8'h03, 0, "R7 index"); send_byte(8'h04, 0, "R7 count");
    send_byte(8'h11, 0, "R7 reg3 ack"); send_byte(8'h22, 0, "R7 reg4 ack");
    send_byte(8'h33, 0, "R7 reg5 ack"); send_byte(8'h44, 0, "R7 reg6 ack");
    bus_stop();
    check("R7 pwr_div2 untouched", d2, 8'h44);

    // R8: read from index 0; count byte first
    bus_start();
    send_byte(8'hD4, 0, "R2 ack"); send_byte(8'h00, 0, "R8 index");
    bus_rstart();
    send_byte(8'hD5, 0, "R2 read address ack");
    recv_byte(8'h04, 0, "R8 count byte");
    recv_byte(8'h30, 0, "R6 reg0 image");
    recv_byte(8'h55, 0, "R8 reg1");
    recv_byte(8'h44, 0, "R8 reg2");
    recv_byte(8'h00, 0, "R7 reg3 zero");
    recv_byte(8'h00, 0, "R7 reg4 zero");
    recv_byte(8'h00, 0, "R7 reg5 zero");
    recv_byte(8'h01, 0, "R7 reg6 id");
    recv_byte(8'h00, 1, "R7 index7 zero");
    wq();
    check("R8 released after nack", {7'd0, s_low}, 8'h00);
    bus_stop();
    check("R9 sda after read stop", {7'd0, s_low}, 8'h00);

    check("scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule